// File: doc/BRIEF.md
# Crate Command Interface

This block is a bus slave that lets an 8-bit microprocessor run a 24-bit crate dataway. One processor memory write into a 512-byte window issues a complete command. The low nine address bits carry the station and the subaddress. The data byte carries the function code and two access-mode flags. Loading the command starts a dataway cycle at once, with no further processor action. The cycle raises a busy line, presents the command and mode flags, and emits two timing strobes in a fixed order from a cycle counter. For a write function it also drives the 24-bit write lines.

Data travels through three byte-wide I/O ports at consecutive addresses, least significant byte first. Writing these ports fills the write register. Reading them returns the read register, which is captured from the dataway on read functions. A fourth port holds a response status byte. This byte is latched at the first strobe and can also be written by software for testing. If the processor touches the block while a cycle runs, the block holds it off with a wait signal until the cycle ends, and the stalled access then completes. Arbitration against other controllers lives elsewhere.

Top module: `crate_cmd_if`

## Requirements
- R1: After reset the busy line, both strobes, the wait line and the write lines are low, and all four ports read zero.
- R2: A memory write whose address bits [15:9] equal those of WIN_BASE loads station = addr[8:4], subaddress = addr[3:0], function = data[4:0], lockout flag = data[5] and hold flag = data[6]. These values stay on the dataway outputs, unchanged, for the whole cycle. A memory write outside the window starts nothing.
- R3: The busy line rises on the clock edge that loads a command. It stays high for exactly T_SETUP+T_S1+T_GAP+T_S2+T_TAIL cycles, and rises at no other time.
- R4: The first strobe is high for T_S1 cycles, starting T_SETUP cycles after busy rises. The second strobe is high for T_S2 cycles, starting T_GAP cycles after the first falls. The two strobes are never high together, and neither is high outside a cycle.
- R5: For function codes 0 to 7 (reads), the read lines are sampled in the first cycle of the first strobe. The sampled value is then readable at I/O ports PORT_BASE+0, +1 and +2 as bits [7:0], [15:8] and [23:16].
- R6: I/O writes to PORT_BASE+0, +1 and +2 fill bytes [7:0], [15:8] and [23:16] of a write register. This register is separate from the read register. For function codes 16 to 23 (writes), its value is driven on the write lines during the cycle. At all other times the write lines are zero.
- R7: Write functions and dataless functions (8 to 15, 24 to 31) leave the read register unchanged.
- R8: The status port PORT_BASE+3 is loaded in the first strobe cycle of every command with bit0 = Q, bit1 = X, bit2 = I, bit3 = the request line, and bits [7:4] = 0. An I/O write to that port stores all eight bits, and a read returns them.
- R9: A command write or port access made while busy is high raises the wait output in the same cycle. The wait output stays high until busy falls, and the access then takes effect. A stalled command starts the next cycle.
- R10: I/O reads of addresses outside the four ports return zero, and I/O writes there change no port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address (memory or I/O) |
| cpu_wdata | input | 8 | Processor write data |
| cpu_mem_wr | input | 1 | Memory write strobe |
| cpu_io_wr | input | 1 | I/O write strobe |
| cpu_io_rd | input | 1 | I/O read strobe |
| cpu_rdata | output | 8 | I/O read data |
| cpu_wait | output | 1 | Stall request to the processor |
| dw_n | output | 5 | Station number |
| dw_a | output | 4 | Subaddress |
| dw_f | output | 5 | Function code |
| dw_lockout | output | 1 | Lockout access-mode flag |
| dw_maintain | output | 1 | Keep-dataway-held flag |
| dw_w | output | DW | Write data lines |
| dw_r | input | DW | Read data lines |
| dw_x | input | 1 | Command-accepted response |
| dw_q | input | 1 | Q response |
| dw_i | input | 1 | Inhibit line |
| dw_lam | input | 1 | Request (demand) line |
| dw_s1 | output | 1 | First timing strobe |
| dw_s2 | output | 1 | Second timing strobe |
| dw_busy | output | 1 | Dataway cycle in progress |

## Verification
The hardest state to reach from the ports is a processor access that collides with a running cycle. The stall has to last to the exact cycle where busy falls, and the held access must then land. This covers both a held status read and a held command write that has to start a fresh cycle back to back. Directed sequences issue a command and then, a few cycles into it, present a port read or a second command, count the stalled cycles, and check what finally lands. Randomized commands drawn from all three function classes, with random window offsets, mode flags, response lines and data, cover the capture and drive paths around these cases.

// File: rtl/crate_pkg.sv
`timescale 1ns/1ps
package crate_pkg;

   typedef enum logic [2:0] {
      PH_IDLE, PH_SETUP, PH_S1, PH_GAP, PH_S2, PH_TAIL
   } phase_t;

   typedef enum logic [1:0] {
      FN_READ, FN_WRITE, FN_NODATA
   } fn_class_t;

   typedef struct packed {
      logic       maintain;
      logic       lockout;
      logic [4:0] f;
      logic [3:0] a;
      logic [4:0] n;
   } cmd_t;

   // 0..7 read, 16..23 write, everything else carries no data
   function automatic fn_class_t classify(input logic [4:0] f);
      case (f[4:3])
         2'b00:   return FN_READ;
         2'b10:   return FN_WRITE;
         default: return FN_NODATA;
      endcase
   endfunction

endpackage

// File: rtl/crate_seq.sv
`timescale 1ns/1ps
module crate_seq #(
   parameter int T_SETUP = 10,
   parameter int T_S1    = 30,
   parameter int T_GAP   = 10,
   parameter int T_S2    = 30,
   parameter int T_TAIL  = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic s1,
   output logic s2,
   output logic capture
);
   import crate_pkg::*;

   localparam int M1     = (T_SETUP > T_S1) ? T_SETUP : T_S1;
   localparam int M2     = (T_GAP > T_S2) ? T_GAP : T_S2;
   localparam int M3     = (M1 > M2) ? M1 : M2;
   localparam int MAXLEN = (M3 > T_TAIL) ? M3 : T_TAIL;
   localparam int CW     = $clog2(MAXLEN + 1);

   phase_t        ph_q, ph_d;
   logic [CW-1:0] cnt_q, cnt_d;

   function automatic logic [CW-1:0] last_of(input phase_t p);
      case (p)
         PH_SETUP: return CW'(T_SETUP - 1);
         PH_S1:    return CW'(T_S1 - 1);
         PH_GAP:   return CW'(T_GAP - 1);
         PH_S2:    return CW'(T_S2 - 1);
         PH_TAIL:  return CW'(T_TAIL - 1);
         default:  return '0;
      endcase
   endfunction

   function automatic phase_t succ(input phase_t p);
      case (p)
         PH_SETUP: return PH_S1;
         PH_S1:    return PH_GAP;
         PH_GAP:   return PH_S2;
         PH_S2:    return PH_TAIL;
         default:  return PH_IDLE;
      endcase
   endfunction

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      if (ph_q == PH_IDLE) begin
         if (start) begin
            ph_d  = PH_SETUP;
            cnt_d = '0;
         end
      end else if (cnt_q == last_of(ph_q)) begin
         ph_d  = succ(ph_q);
         cnt_d = '0;
      end else begin
         cnt_d = cnt_q + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
      end
   end

   assign busy    = (ph_q != PH_IDLE);
   assign s1      = (ph_q == PH_S1);
   assign s2      = (ph_q == PH_S2);
   assign capture = (ph_q == PH_S1) && (cnt_q == '0);

endmodule

// File: rtl/crate_decode.sv
`timescale 1ns/1ps
module crate_decode #(
   parameter logic [15:0] WIN_BASE  = 16'h3E00,
   parameter logic [7:0]  PORT_BASE = 8'h08,
   parameter int          NPORT     = 4
) (
   input  logic [6:0]       win_tag,
   input  logic [7:0]       io_addr,
   input  logic             mem_wr,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic             busy,
   output logic             cmd_load,
   output logic [NPORT-1:0] port_wr,
   output logic [NPORT-1:0] port_rd,
   output logic             wait_o
);
   logic cmd_hit, io_hit, any_access;

   assign cmd_hit    = mem_wr && (win_tag == WIN_BASE[15:9]);
   assign io_hit     = (io_addr[7:2] == PORT_BASE[7:2]);
   assign any_access = cmd_hit || (io_hit && (io_rd || io_wr));
   assign wait_o     = busy && any_access;
   assign cmd_load   = cmd_hit && !busy;

   for (genvar i = 0; i < NPORT; i++) begin : g_sel
      logic sel;
      assign sel        = io_hit && (io_addr[1:0] == 2'(i)) && !busy;
      assign port_wr[i] = sel && io_wr;
      assign port_rd[i] = sel && io_rd;
   end

endmodule

// File: rtl/crate_regs.sv
`timescale 1ns/1ps
module crate_regs #(
   parameter int LANES = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_load,
   input  crate_pkg::cmd_t       cmd_in,
   input  logic [LANES:0]        port_wr,
   input  logic [LANES:0]        port_rd,
   input  logic [7:0]            wdata,
   input  logic                  capture,
   input  logic [8*LANES-1:0]    dw_r,
   input  logic [3:0]            resp,
   output crate_pkg::cmd_t       cmd_q,
   output logic [8*LANES-1:0]    wr_q,
   output logic [7:0]            rdata
);
   import crate_pkg::*;

   logic [8*LANES-1:0] rd_q;
   logic [7:0]         stat_q;
   logic               is_read;

   assign is_read = (classify(cmd_q.f) == FN_READ);

   always_ff @(posedge clk) begin
      if (!rst_n)        cmd_q <= '0;
      else if (cmd_load) cmd_q <= cmd_in;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)          wr_q[8*i +: 8] <= '0;
         else if (port_wr[i]) wr_q[8*i +: 8] <= wdata;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)                  rd_q[8*i +: 8] <= '0;
         else if (capture && is_read) rd_q[8*i +: 8] <= dw_r[8*i +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              stat_q <= '0;
      else if (capture)        stat_q <= {4'b0000, resp};
      else if (port_wr[LANES]) stat_q <= wdata;
   end

   always_comb begin
      rdata = {8{port_rd[LANES]}} & stat_q;
      for (int i = 0; i < LANES; i++) begin
         rdata = rdata | ({8{port_rd[i]}} & rd_q[8*i +: 8]);
      end
   end

endmodule

// File: rtl/crate_cmd_if.sv
`timescale 1ns/1ps
module crate_cmd_if #(
   parameter logic [15:0] WIN_BASE  = 16'h3E00,
   parameter logic [7:0]  PORT_BASE = 8'h08,
   parameter int          DW        = 24,
   parameter int          T_SETUP   = 10,
   parameter int          T_S1      = 30,
   parameter int          T_GAP     = 10,
   parameter int          T_S2      = 30,
   parameter int          T_TAIL    = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [15:0]   cpu_addr,
   input  logic [7:0]    cpu_wdata,
   input  logic          cpu_mem_wr,
   input  logic          cpu_io_wr,
   input  logic          cpu_io_rd,
   output logic [7:0]    cpu_rdata,
   output logic          cpu_wait,
   output logic [4:0]    dw_n,
   output logic [3:0]    dw_a,
   output logic [4:0]    dw_f,
   output logic          dw_lockout,
   output logic          dw_maintain,
   output logic [DW-1:0] dw_w,
   input  logic [DW-1:0] dw_r,
   input  logic          dw_x,
   input  logic          dw_q,
   input  logic          dw_i,
   input  logic          dw_lam,
   output logic          dw_s1,
   output logic          dw_s2,
   output logic          dw_busy
);
   import crate_pkg::*;

   localparam int LANES = DW / 8;
   localparam int NPORT = LANES + 1;

   if (WIN_BASE[8:0] != 9'd0) begin : g_bad_win
      $error("WIN_BASE must be aligned to 512 bytes");
   end
   if (PORT_BASE[1:0] != 2'd0) begin : g_bad_port
      $error("PORT_BASE must be aligned to 4");
   end
   if ((DW % 8) != 0 || DW < 8 || DW > 24) begin : g_bad_dw
      $error("DW must be 8, 16 or 24");
   end
   if (T_SETUP < 1 || T_S1 < 1 || T_GAP < 1 || T_S2 < 1 || T_TAIL < 1) begin : g_bad_t
      $error("every phase length must be at least one cycle");
   end

   logic             busy, s1, s2, capture, cmd_load;
   logic [NPORT-1:0] port_wr, port_rd;
   cmd_t             cmd_in, cmd_q;
   logic [DW-1:0]    wr_q;

   assign cmd_in = '{maintain: cpu_wdata[6], lockout: cpu_wdata[5],
                     f: cpu_wdata[4:0], a: cpu_addr[3:0], n: cpu_addr[8:4]};

   crate_decode #(.WIN_BASE(WIN_BASE), .PORT_BASE(PORT_BASE), .NPORT(NPORT)) i_decode (
      .win_tag (cpu_addr[15:9]),
      .io_addr (cpu_addr[7:0]),
      .mem_wr  (cpu_mem_wr),
      .io_wr   (cpu_io_wr),
      .io_rd   (cpu_io_rd),
      .busy    (busy),
      .cmd_load(cmd_load),
      .port_wr (port_wr),
      .port_rd (port_rd),
      .wait_o  (cpu_wait)
   );

   crate_seq #(.T_SETUP(T_SETUP), .T_S1(T_S1), .T_GAP(T_GAP), .T_S2(T_S2), .T_TAIL(T_TAIL)) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (cmd_load),
      .busy   (busy),
      .s1     (s1),
      .s2     (s2),
      .capture(capture)
   );

   crate_regs #(.LANES(LANES)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_load(cmd_load),
      .cmd_in  (cmd_in),
      .port_wr (port_wr),
      .port_rd (port_rd),
      .wdata   (cpu_wdata),
      .capture (capture),
      .dw_r    (dw_r),
      .resp    ({dw_lam, dw_i, dw_x, dw_q}),
      .cmd_q   (cmd_q),
      .wr_q    (wr_q),
      .rdata   (cpu_rdata)
   );

   assign dw_busy     = busy;
   assign dw_s1       = s1;
   assign dw_s2       = s2;
   assign dw_n        = busy ? cmd_q.n : '0;
   assign dw_a        = busy ? cmd_q.a : '0;
   assign dw_f        = busy ? cmd_q.f : '0;
   assign dw_lockout  = busy && cmd_q.lockout;
   assign dw_maintain = busy && cmd_q.maintain;
   assign dw_w        = (busy && classify(cmd_q.f) == FN_WRITE) ? wr_q : '0;

endmodule

// File: rtl/crate_cmd_if_chk.sv
`timescale 1ns/1ps
module crate_cmd_if_chk #(
   parameter int DW   = 24,
   parameter int T_S1 = 30
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_mem_wr,
   input logic          cpu_wait,
   input logic          dw_busy,
   input logic          dw_s1,
   input logic          dw_s2,
   input logic [4:0]    dw_n,
   input logic [4:0]    dw_f,
   input logic [DW-1:0] dw_w
);
   localparam int RW = $clog2(T_S1 + 2);

   logic [RW-1:0] s1_run;

   always_ff @(posedge clk) begin
      if (!rst_n)     s1_run <= '0;
      else if (dw_s1) s1_run <= s1_run + RW'(1);
      else            s1_run <= '0;
   end

   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dw_s1 && dw_s2));

   // R4
   strobe_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_s1 || dw_s2) |-> dw_busy);

   // R4
   s1_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dw_s1) |-> (s1_run == RW'(T_S1)));

   // R9
   wait_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wait |-> dw_busy);

   // R3
   start_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dw_busy) |-> $past(cpu_mem_wr));

   // R2
   cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_busy && $past(dw_busy)) |-> ($stable(dw_n) && $stable(dw_f)));

   // R6
   w_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dw_busy |-> (dw_w == '0));

endmodule

bind crate_cmd_if crate_cmd_if_chk #(.DW(DW), .T_S1(T_S1)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_mem_wr(cpu_mem_wr),
   .cpu_wait  (cpu_wait),
   .dw_busy   (dw_busy),
   .dw_s1     (dw_s1),
   .dw_s2     (dw_s2),
   .dw_n      (dw_n),
   .dw_f      (dw_f),
   .dw_w      (dw_w)
);

// File: tb/test_crate_cmd_if.sv
`timescale 1ns/1ps
module test_crate_cmd_if;
   localparam logic [15:0] WIN  = 16'h3E00;
   localparam logic [7:0]  PB   = 8'h08;
   localparam int TSU = 10, TS1 = 30, TG = 10, TS2 = 30, TT = 20;
   localparam int TOT = TSU + TS1 + TG + TS2 + TT;
   localparam int S2B = TSU + TS1 + TG;

   logic        clk = 0, rst_n = 0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_mem_wr = 0, cpu_io_wr = 0, cpu_io_rd = 0;
   logic [7:0]  cpu_rdata;
   logic        cpu_wait;
   logic [4:0]  dw_n, dw_f;
   logic [3:0]  dw_a;
   logic        dw_lockout, dw_maintain, dw_s1, dw_s2, dw_busy;
   logic [23:0] dw_w;
   logic [23:0] dw_r = '0;
   logic        dw_x = 0, dw_q = 0, dw_i = 0, dw_lam = 0;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [23:0] wr_m = '0, rd_m = '0;
   logic [7:0]  st_m = '0;

   crate_cmd_if #(.WIN_BASE(WIN), .PORT_BASE(PB), .DW(24), .T_SETUP(TSU), .T_S1(TS1),
                  .T_GAP(TG), .T_S2(TS2), .T_TAIL(TT)) i_crate_cmd_if (.*);

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit is_rd(input logic [4:0] f); return f < 8; endfunction
   function automatic bit is_wr(input logic [4:0] f); return f >= 16 && f < 24; endfunction

   task automatic mem_wr(input logic [15:0] addr, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = addr; cpu_wdata = d; cpu_mem_wr = 1;
      #1;
      while (cpu_wait) begin @(negedge clk); #1; end
      @(negedge clk);
      cpu_mem_wr = 0;
      #1;
   endtask

   task automatic io_wr(input logic [7:0] port, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = {8'h00, port}; cpu_wdata = d; cpu_io_wr = 1;
      #1;
      while (cpu_wait) begin @(negedge clk); #1; end
      @(negedge clk);
      cpu_io_wr = 0;
      #1;
   endtask

   task automatic io_rd(input logic [7:0] port, output logic [7:0] d);
      @(negedge clk);
      cpu_addr = {8'h00, port}; cpu_io_rd = 1;
      #1;
      while (cpu_wait) begin @(negedge clk); #1; end
      d = cpu_rdata;
      cpu_io_rd = 0;
   endtask

   task automatic load_wr(input logic [23:0] v);
      io_wr(PB + 0, v[7:0]);
      io_wr(PB + 1, v[15:8]);
      io_wr(PB + 2, v[23:16]);
      wr_m = v;
   endtask

   task automatic check_ports(input string tag);
      logic [7:0] b;
      io_rd(PB + 0, b); chk({tag, " R5 byte0"}, b, rd_m[7:0]);
      io_rd(PB + 1, b); chk({tag, " R5 byte1"}, b, rd_m[15:8]);
      io_rd(PB + 2, b); chk({tag, " R5 byte2"}, b, rd_m[23:16]);
      io_rd(PB + 3, b); chk({tag, " R8 status"}, b, st_m);
   endtask

   task automatic run_cmd(input logic [4:0] n, input logic [3:0] a, input logic [4:0] f,
                          input logic lk, input logic mt);
      int bm = 0, s1m = 0, s2m = 0;
      mem_wr(WIN | {7'd0, n, a}, {1'b0, mt, lk, f});
      for (int k = 0; k < TOT + 2; k++) begin
         if (dw_busy !== (k < TOT)) bm++;
         if (dw_s1 !== (k >= TSU && k < TSU + TS1)) s1m++;
         if (dw_s2 !== (k >= S2B && k < S2B + TS2)) s2m++;
         if (k == 0) begin
            chk("R2 station", dw_n, n);
            chk("R2 subaddr", dw_a, a);
            chk("R2 function", dw_f, f);
            chk("R2 flags", {dw_maintain, dw_lockout}, {mt, lk});
         end
         if (k == TSU) chk("R6 write lines", dw_w, is_wr(f) ? wr_m : 24'd0);
         @(negedge clk); #1;
      end
      chk("R3 busy window", bm, 0);
      chk("R4 first strobe", s1m, 0);
      chk("R4 second strobe", s2m, 0);
      if (is_rd(f)) rd_m = dw_r;
      st_m = {4'b0000, dw_lam, dw_i, dw_x, dw_q};
      check_ports(is_rd(f) ? "read" : "R7 no-read");
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL R3 watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      int cnt;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1 reset state
      chk("R1 busy", dw_busy, 0);
      chk("R1 strobes", {dw_s1, dw_s2}, 2'b00);
      chk("R1 wait", cpu_wait, 0);
      chk("R1 write lines", dw_w, 0);
      check_ports("R1");

      // R6 write register separate from read register
      load_wr(24'hC3B2A1);
      io_rd(PB + 0, b); chk("R6 port0 returns read reg", b, rd_m[7:0]);

      // directed corners: window edges, each function class
      dw_r = 24'h123456; {dw_lam, dw_i, dw_x, dw_q} = 4'b1011;
      run_cmd(5'd0, 4'd0, 5'd0, 1'b0, 1'b0);
      dw_r = 24'hFEDCBA; {dw_lam, dw_i, dw_x, dw_q} = 4'b0100;
      run_cmd(5'd31, 4'd15, 5'd23, 1'b1, 1'b1);
      run_cmd(5'd9, 4'd2, 5'd31, 1'b1, 1'b0);
      run_cmd(5'd1, 4'd7, 5'd16, 1'b0, 1'b1);

      // R8 software write of status
      io_wr(PB + 3, 8'hA5); st_m = 8'hA5;
      io_rd(PB + 3, b); chk("R8 status written", b, 8'hA5);

      // R2 writes just outside the window start nothing
      mem_wr(WIN + 16'h0200, 8'h00); chk("R2 above window", dw_busy, 0);
      mem_wr(WIN - 16'h0001, 8'h00); chk("R2 below window", dw_busy, 0);

      // R10 unused I/O addresses
      io_wr(PB + 4, 8'hFF); io_wr(PB - 1, 8'hFF);
      io_rd(PB + 4, b); chk("R10 read outside", b, 0);
      check_ports("R10");

      // R9 held status read during a cycle
      dw_r = 24'h5A5A5A; {dw_lam, dw_i, dw_x, dw_q} = 4'b0110;
      mem_wr(WIN, 8'h00);
      repeat (2) @(negedge clk);
      cpu_addr = {8'h00, PB + 8'd3}; cpu_io_rd = 1;
      #1;
      chk("R9 wait raised", cpu_wait, 1);
      cnt = 0;
      while (cpu_wait) begin @(negedge clk); #1; cnt++; end
      chk("R9 stall length", cnt, TOT - 2);
      chk("R9 busy low at release", dw_busy, 0);
      chk("R9 held read value", cpu_rdata, 8'h06);
      cpu_io_rd = 0;
      rd_m = dw_r; st_m = 8'h06;

      // R9 held command starts the next cycle
      mem_wr(WIN | 16'h0011, 8'h10);
      mem_wr(WIN | 16'h0073, 8'h01);
      chk("R9 held cmd busy", dw_busy, 1);
      chk("R9 held cmd function", dw_f, 5'd1);
      chk("R9 held cmd station", dw_n, 5'd7);
      while (dw_busy) begin @(negedge clk); #1; end
      rd_m = dw_r;
      check_ports("R9 held");

      // random commands over all classes
      for (int it = 0; it < 40; it++) begin
         logic [4:0] f;
         int cls = $urandom % 3;
         load_wr(24'($urandom));
         dw_r = 24'($urandom);
         {dw_lam, dw_i, dw_x, dw_q} = 4'($urandom);
         if (cls == 0)      f = 5'($urandom % 8);
         else if (cls == 1) f = 5'(16 + $urandom % 8);
         else               f = 5'(8 + $urandom % 8 + (($urandom % 2) * 16));
         run_cmd(5'($urandom), 4'($urandom), f, 1'($urandom), 1'($urandom));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule